// File: doc/BRIEF.md
# Phase-zero SPI master byte exchanger

This block is the serial side of an 8-bit SPI master that uses the clock-phase-zero transfer format. A host writes one byte through a single-cycle write strobe. The block then drives slave select low and generates the serial clock from a programmable half-period divider. It clocks the byte out on MOSI while it takes the slave's byte in on MISO. The master's shift register and the slave's register form one 16-bit ring, so a full transfer swaps the two bytes.

Each received bit is caught in a one-bit holding latch on the odd (leading) clock edge. On the following even (trailing) edge the latched bit is shifted into the register, and the next outgoing bit appears on MOSI. Reception is double buffered. The host-visible receive register changes only once, at the close of a transfer, and then holds the complete received byte. The clock polarity and the bit order are configuration inputs. The host sees a busy flag, a sticky transfer-complete flag and a sticky write-collision flag.

Top module: `spi_xfer_engine`

## Requirements
- R1: After synchronous reset, ss_n is 1, sck equals cpol, busy, done and wcol are 0, and rx_data is 0x00.
- R2: A write (wr_en=1) sampled while idle makes ss_n 0 and busy 1 from the next cycle. The first outgoing bit is already on MOSI from the moment ss_n goes low.
- R3: The first sck edge comes DIV system clocks after the accepting clock edge. DIV is half_div, latched at the accepting edge, with a value of 0 treated as 1. Each later edge follows the previous one by DIV clocks, there are exactly 16 edges, and between transfers sck rests at the cpol level.
- R4: The MISO level is captured on each odd sck edge and shifted into the register on the following even edge. When a transfer ends, the slave holds the master's byte and the master holds the slave's byte.
- R5: rx_data changes only on the clock edge where busy falls, and takes the byte received during that transfer. At all other times it holds its value.
- R6: With lsb_first=0, bits travel most significant first: they leave from bit 7 and enter at bit 0. With lsb_first=1, bits travel least significant first: they leave from bit 0 and enter at bit 7.
- R7: ss_n returns to 1 DIV clocks after the 16th edge. On that same clock edge, busy falls and done becomes 1. done returns to 0 on the next accepted write.
- R8: A write sampled while busy is ignored and sets wcol to 1. The ignored write does not change the byte sent, the byte received, or the timing. wcol returns to 0 on the next accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe for the transmit byte |
| wr_data | input | 8 | Byte to send to the slave |
| cpol | input | 1 | Serial clock idle level |
| lsb_first | input | 1 | 1 selects least-significant-bit-first order |
| half_div | input | 8 | SCK half period in system clocks (0 treated as 1) |
| miso | input | 1 | Serial data from the slave |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| ss_n | output | 1 | Active-low slave select |
| rx_data | output | 8 | Last byte received from the slave |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Sticky transfer-complete flag |
| wcol | output | 1 | Sticky write-collision flag |

## Verification
Two functions can fall on the same clock edge: the completion of a transfer and a host write that arrives exactly then. The bench times a write strobe to be sampled on the very edge where ss_n rises and the receive register is loaded. At that edge the block must still count as busy. The expected result is that rx_data loads the slave's byte, done and wcol both set, and no new transfer starts. A cycle-by-cycle behavioural model, together with a slave model on the serial pins, judges every cycle of that window.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

    localparam int BYTE_W  = 8;
    localparam int DIV_W   = 8;
    localparam int N_EDGES = 2 * BYTE_W;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_EDGE  = 2'd2,
        ST_TRAIL = 2'd3
    } xfer_state_t;

    typedef struct packed {
        logic start;
        logic odd_edge;
        logic even_edge;
        logic finish;
    } xfer_evt_t;

    function automatic logic out_bit(input logic [BYTE_W-1:0] v, input logic lsb_first);
        return lsb_first ? v[0] : v[BYTE_W-1];
    endfunction

    function automatic logic [BYTE_W-1:0] shift_in(input logic [BYTE_W-1:0] v,
                                                   input logic bit_in,
                                                   input logic lsb_first);
        return lsb_first ? {bit_in, v[BYTE_W-1:1]} : {v[BYTE_W-2:0], bit_in};
    endfunction

endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer
    import spi_xfer_pkg::*;
#(
    parameter int DW = DIV_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [DW-1:0] limit,
    output logic          tick
);

    logic [DW-1:0] cnt;

    assign tick = run && (cnt == limit - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R3: with a half period above one clock, edges never come back to back
    a_r3_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        (tick && limit > 1) |=> !tick);

endmodule

// File: rtl/spi_xfer_seq.sv
module spi_xfer_seq
    import spi_xfer_pkg::*;
#(
    parameter int DW = DIV_W,
    parameter int NE = N_EDGES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] half_div,
    output xfer_evt_t     evt,
    output logic          busy,
    output logic          ss_n,
    output logic          sck_tog
);

    localparam int EW = $clog2(NE + 1);

    xfer_state_t   state;
    logic [EW-1:0] edge_cnt;
    logic [DW-1:0] div_q;
    logic          tick;
    logic          run;

    assign run  = (state != ST_IDLE);
    assign busy = run;

    spi_half_timer #(.DW(DW)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .run   (run),
        .limit (div_q),
        .tick  (tick)
    );

    always_comb begin
        evt.start     = (state == ST_IDLE) && wr_en;
        evt.odd_edge  = tick && ((state == ST_LEAD) ||
                                 (state == ST_EDGE && !edge_cnt[0]));
        evt.even_edge = tick && (state == ST_EDGE) && edge_cnt[0];
        evt.finish    = tick && (state == ST_TRAIL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            edge_cnt <= '0;
            div_q    <= {{(DW-1){1'b0}}, 1'b1};
            ss_n     <= 1'b1;
            sck_tog  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (wr_en) begin
                        state    <= ST_LEAD;
                        edge_cnt <= '0;
                        div_q    <= (half_div == '0) ? {{(DW-1){1'b0}}, 1'b1} : half_div;
                        ss_n     <= 1'b0;
                    end
                end
                ST_LEAD: begin
                    if (tick) begin
                        state    <= ST_EDGE;
                        edge_cnt <= EW'(1);
                        sck_tog  <= ~sck_tog;
                    end
                end
                ST_EDGE: begin
                    if (tick) begin
                        edge_cnt <= edge_cnt + 1'b1;
                        sck_tog  <= ~sck_tog;
                        if (edge_cnt == EW'(NE - 1)) begin
                            state <= ST_TRAIL;
                        end
                    end
                end
                default: begin
                    if (tick) begin
                        state <= ST_IDLE;
                        ss_n  <= 1'b1;
                    end
                end
            endcase
        end
    end

    // R3: never more than the full edge count in one transfer
    a_r3_edge_bound: assert property (@(posedge clk) disable iff (rst)
        edge_cnt <= EW'(NE));

    // R3: the clock is back at rest whenever select releases
    a_r3_rest_on_release: assert property (@(posedge clk) disable iff (rst)
        $rose(ss_n) |-> !sck_tog);

    // R7: completion ends busy and releases select together
    a_r7_release: assert property (@(posedge clk) disable iff (rst)
        evt.finish |=> (ss_n && !busy));

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
    import spi_xfer_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         lsb_first,
    input  logic         odd_edge,
    input  logic         even_edge,
    input  logic         miso,
    output logic         mosi,
    output logic [W-1:0] shreg
);

    logic hold;

    assign mosi = out_bit(shreg, lsb_first);

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            hold  <= 1'b0;
        end else if (load) begin
            shreg <= load_data;
        end else begin
            if (odd_edge) begin
                hold <= miso;
            end
            if (even_edge) begin
                shreg <= shift_in(shreg, hold, lsb_first);
            end
        end
    end

    // R4: the outgoing bit moves only at a trailing edge or a fresh load
    a_r4_mosi_moves_on_even: assert property (@(posedge clk) disable iff (rst)
        (!$stable(mosi) && $stable(lsb_first) && !$past(load)) |-> $past(even_edge));

endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
    import spi_xfer_pkg::*;
#(
    parameter int W  = BYTE_W,
    parameter int DW = DIV_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic          cpol,
    input  logic          lsb_first,
    input  logic [DW-1:0] half_div,
    input  logic          miso,
    output logic          sck,
    output logic          mosi,
    output logic          ss_n,
    output logic [W-1:0]  rx_data,
    output logic          busy,
    output logic          done,
    output logic          wcol
);

    xfer_evt_t    evt;
    logic         sck_tog;
    logic [W-1:0] shreg;

    spi_xfer_seq #(.DW(DW), .NE(2 * W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .half_div (half_div),
        .evt      (evt),
        .busy     (busy),
        .ss_n     (ss_n),
        .sck_tog  (sck_tog)
    );

    spi_shift_core #(.W(W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (evt.start),
        .load_data (wr_data),
        .lsb_first (lsb_first),
        .odd_edge  (evt.odd_edge),
        .even_edge (evt.even_edge),
        .miso      (miso),
        .mosi      (mosi),
        .shreg     (shreg)
    );

    assign sck = cpol ^ sck_tog;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data <= '0;
            done    <= 1'b0;
            wcol    <= 1'b0;
        end else begin
            if (evt.start) begin
                done <= 1'b0;
                wcol <= 1'b0;
            end else if (busy && wr_en) begin
                wcol <= 1'b1;
            end
            if (evt.finish) begin
                rx_data <= shreg;
                done    <= 1'b1;
            end
        end
    end

    // R1: serial clock rests at the polarity level while deselected
    a_r1_sck_rest: assert property (@(posedge clk) disable iff (rst)
        ss_n |-> (sck == cpol));

    // R5: the receive buffer changes only as busy falls
    a_r5_rx_hold: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_data) |-> $fell(busy));

    // R8: a write during a transfer raises the collision flag
    a_r8_collision: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_en) |=> wcol);

    // R2: an idle write selects the slave on the next cycle
    a_r2_select: assert property (@(posedge clk) disable iff (rst)
        (!busy && wr_en) |=> (!ss_n && busy));

endmodule

// File: tb/spi_xfer_engine_tb_top.sv
`timescale 1ns/1ps
module spi_xfer_engine_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       cpol = 1'b0;
    logic       lsb_first = 1'b0;
    logic [7:0] half_div = 8'd1;
    logic       miso = 1'b0;
    logic       sck, mosi, ss_n, busy, done, wcol;
    logic [7:0] rx_data;

    always #4 clk = ~clk;

    spi_xfer_engine dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .cpol(cpol), .lsb_first(lsb_first), .half_div(half_div), .miso(miso),
        .sck(sck), .mosi(mosi), .ss_n(ss_n), .rx_data(rx_data),
        .busy(busy), .done(done), .wcol(wcol)
    );

    int n_checks = 0;
    int n_errors = 0;
    int cycles = 0;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // behavioural slave on the serial pins
    logic [7:0] s_tx = 8'h00;
    logic [7:0] s_reg = 8'h00;
    logic       s_lat = 1'b0;

    always @(negedge ss_n) begin
        s_reg = s_tx;
        miso  = lsb_first ? s_reg[0] : s_reg[7];
    end

    always @(sck) begin
        if (ss_n === 1'b0) begin
            if (sck != cpol) begin
                s_lat = mosi;
            end else begin
                s_reg = lsb_first ? {s_lat, s_reg[7:1]} : {s_reg[6:0], s_lat};
                miso  = lsb_first ? s_reg[0] : s_reg[7];
            end
        end
    end

    // cycle-level reference model
    logic       m_busy, m_ss, m_tog, m_done, m_col;
    logic [7:0] m_rx, m_tx, m_stx;
    logic       m_lsb;
    int         m_div, m_cnt, m_edges;

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_ss = 1; m_tog = 0; m_done = 0; m_col = 0;
            m_rx = 0; m_cnt = 0; m_edges = 0; m_div = 1;
        end else if (!m_busy) begin
            if (wr_en) begin
                m_busy = 1; m_ss = 0; m_cnt = 0; m_edges = 0;
                m_div = (half_div == 0) ? 1 : int'(half_div);
                m_done = 0; m_col = 0; m_tx = wr_data; m_stx = s_tx; m_lsb = lsb_first;
            end
        end else begin
            if (wr_en) m_col = 1;
            m_cnt++;
            if (m_cnt == m_div) begin
                m_cnt = 0;
                m_edges++;
                if (m_edges <= 16) m_tog = ~m_tog;
                else begin
                    m_ss = 1; m_busy = 0; m_done = 1; m_rx = m_stx;
                    check(m_lsb ? "R6" : "R4", "slave received byte", s_reg, m_tx);
                end
            end
        end
    end

    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            check("R2", "ss_n", ss_n, m_ss);
            check("R3", "sck", sck, cpol ^ m_tog);
            check("R7", "busy", busy, m_busy);
            check("R7", "done", done, m_done);
            check("R8", "wcol", wcol, m_col);
            check("R5", "rx_data", rx_data, m_rx);
        end
        if (cycles > 150000) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    task automatic do_write(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        while (m_busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] m, input logic [7:0] s,
                        input logic p, input logic l, input logic [7:0] dv);
        @(negedge clk);
        cpol = p; lsb_first = l; half_div = dv; s_tx = s;
        repeat (2) @(negedge clk);
        do_write(m);
        // R2: first bit on MOSI as select asserts
        check("R2", "first mosi bit", mosi, l ? m[0] : m[7]);
        wait_idle();
        check("R5", "rx after transfer", rx_data, s);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "ss_n", ss_n, 1);
        check("R1", "sck", sck, 0);
        check("R1", "busy", busy, 0);
        check("R1", "done", done, 0);
        check("R1", "wcol", wcol, 0);
        check("R1", "rx_data", rx_data, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        xfer(8'hA5, 8'h3C, 1'b0, 1'b0, 8'd1);
        xfer(8'h81, 8'hE4, 1'b1, 1'b0, 8'd3);
        xfer(8'h1E, 8'h97, 1'b0, 1'b1, 8'd2);   // R6 LSB first
        xfer(8'hF0, 8'h0D, 1'b1, 1'b1, 8'd0);   // R3 zero divider acts as one

        // R8: write in the middle of a transfer is ignored
        @(negedge clk);
        cpol = 0; lsb_first = 0; half_div = 8'd2; s_tx = 8'h6B;
        do_write(8'h52);
        repeat (9) @(negedge clk);
        do_write(8'hFF);
        wait_idle();
        check("R8", "collision flag", wcol, 1);
        check("R8", "rx unaffected", rx_data, 8'h6B);

        // R7/R8: write lands on the completion edge
        @(negedge clk);
        half_div = 8'd3; s_tx = 8'hC9;
        do_write(8'h27);
        repeat (17 * 3 - 1) @(negedge clk);
        wr_en = 1'b1; wr_data = 8'h99;
        @(negedge clk);
        wr_en = 1'b0;
        check("R7", "done at collision edge", done, 1);
        check("R8", "wcol at collision edge", wcol, 1);
        check("R8", "no restart", busy, 0);
        check("R5", "rx at collision edge", rx_data, 8'hC9);

        // R7/R8: next accepted write clears the flags
        do_write(8'h44);
        check("R7", "done cleared", done, 0);
        check("R8", "wcol cleared", wcol, 0);
        wait_idle();

        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule